// File: doc/BRIEF.md
# Isolation Domain Freeze Filter

This block sits in the transaction path of a PCIe host bridge. It keeps a small state table with one entry per isolation domain. Each entry holds two freeze flags. The MMIO flag guards outbound traffic from the CPU. The DMA flag guards inbound traffic, including message-signalled interrupts. An error-reporting source raises a freeze on a domain, which sets both flags at once. Software then clears each flag on its own, for example to re-enable MMIO for diagnosis while DMA stays fenced.

Every transaction that reaches the filter carries a domain number, a kind (load, store or MSI) and a direction. If the flag that applies to the transaction is clear, the filter forwards the transaction unchanged with one cycle of latency. If that flag is set:
- stores and MSIs are discarded;
- loads are completed locally with all-ones data, on the same one-cycle schedule as the forwarded path.

Each bridge instance owns its own table. Domain lookup and error-detail capture happen elsewhere.

Top module: `frz_filter`

## Requirements
- R1: After reset every freeze flag of every domain reads 0, and neither the forward beat nor the local completion is valid.
- R2: A freeze request for domain d sets both the MMIO flag and the DMA flag of d on the same clock edge. The status outputs show this from the next cycle.
- R3: A clear request clears the MMIO flag when `clrMmio` is 1 and the DMA flag when `clrDma` is 1. A flag that is not selected keeps its value.
- R4: A freeze request and a clear request for the same domain in the same cycle leave both flags set.
- R5: The flag that gates a transaction is selected as follows:
  - An outbound (`txInbound`=0) load or store is gated by the MMIO flag.
  - An inbound (`txInbound`=1) load or store is gated by the DMA flag.
  - An MSI (`txKind`=2) is always gated by the DMA flag.
- R6: A gated store (`txKind`=1, or reserved code 3) or a gated MSI produces no forward beat and no completion.
- R7: A gated load (`txKind`=0) produces no forward beat. One cycle later it produces a completion beat that carries the domain number, with all data bits equal to 1.
- R8: A transaction whose gating flag is clear appears on the forward port one cycle later, with the same kind, domain, direction and data.
- R9: `frzPulse` is high for one cycle after a freeze request whose domain had at least one flag clear. It stays low after a freeze request to a domain whose two flags are both already set.
- R10: A transaction is gated by the table state as it was before the edge on which it is accepted. A freeze request in the same cycle affects only later transactions.
- R11: `stsMmio` and `stsDma` show the flags of domain `stsDomain` combinationally. Freezing or clearing one domain does not change any other domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frzValid | input | 1 | Freeze request strobe |
| frzDomain | input | DOM_W | Domain to freeze |
| clrValid | input | 1 | Clear request strobe |
| clrDomain | input | DOM_W | Domain to clear |
| clrMmio | input | 1 | Clear the MMIO flag |
| clrDma | input | 1 | Clear the DMA flag |
| txValid | input | 1 | Transaction present |
| txKind | input | 2 | 0 load, 1 store, 2 MSI, 3 reserved (handled as a store) |
| txInbound | input | 1 | 1 for device-to-host traffic, 0 for host-to-device |
| txDomain | input | DOM_W | Domain of the transaction |
| txData | input | DATA_W | Transaction payload |
| stsDomain | input | DOM_W | Domain whose flags are shown |
| stsMmio | output | 1 | MMIO flag of stsDomain |
| stsDma | output | 1 | DMA flag of stsDomain |
| frzPulse | output | 1 | New freeze event |
| fwdValid | output | 1 | Forward beat valid |
| fwdKind | output | 2 | Forwarded kind |
| fwdInbound | output | 1 | Forwarded direction |
| fwdDomain | output | DOM_W | Forwarded domain |
| fwdData | output | DATA_W | Forwarded payload |
| cplValid | output | 1 | Local all-ones completion valid |
| cplDomain | output | DOM_W | Domain of the completed load |
| cplData | output | DATA_W | Completion data |

## Verification
The bench targets the asymmetric cases, where the two flags hold different values.

- With only the DMA flag set, outbound stores must pass while inbound stores and MSIs vanish. A design that picks the wrong flag, or gates MSIs by direction instead of kind, shows this as a missing or extra beat.
- A freeze and a clear aimed at one domain in the same cycle must leave it frozen. A design that lets the clear win shows both status flags at 0.
- A transaction presented together with its domain's freeze must still pass. A design that reads the table after the update returns a completion there.
- A repeated freeze of a fully frozen domain must stay silent. A design that pulses on every request shows a spurious pulse.

// File: rtl/frz_filter_pkg.sv
package frz_filter_pkg;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_MSI   = 2'd2,
    KIND_RSVD  = 2'd3
  } txKind_e;

  // Control-to-datapath strobes, one per accepted transaction.
  typedef struct packed {
    logic fwdEn;  // forward the beat unchanged
    logic cplEn;  // answer a blocked load with all ones
  } gateStrobes_t;

endpackage

// File: rtl/frz_ctrl.sv
module frz_ctrl
  import frz_filter_pkg::*;
#(
  parameter int NUM_DOM = 256,
  localparam int DOM_W = $clog2(NUM_DOM)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frzValid,
  input  logic [DOM_W-1:0] frzDomain,
  input  logic             clrValid,
  input  logic [DOM_W-1:0] clrDomain,
  input  logic             clrMmio,
  input  logic             clrDma,
  input  logic             txValid,
  input  txKind_e          txKind,
  input  logic             txInbound,
  input  logic [DOM_W-1:0] txDomain,
  input  logic [DOM_W-1:0] stsDomain,
  output logic             stsMmio,
  output logic             stsDma,
  output logic             frzPulse,
  output gateStrobes_t     strobes
);

  logic [NUM_DOM-1:0] mmioFrz;
  logic [NUM_DOM-1:0] dmaFrz;

  // One pair of flags per domain; a freeze overrides a same-cycle clear.
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    logic frzHit;
    logic clrHit;
    assign frzHit = frzValid && (frzDomain == DOM_W'(d));
    assign clrHit = clrValid && (clrDomain == DOM_W'(d));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mmioFrz[d] <= 1'b0;
        dmaFrz[d]  <= 1'b0;
      end else if (frzHit) begin
        mmioFrz[d] <= 1'b1;
        dmaFrz[d]  <= 1'b1;
      end else if (clrHit) begin
        if (clrMmio) mmioFrz[d] <= 1'b0;
        if (clrDma)  dmaFrz[d]  <= 1'b0;
      end
    end
  end

  // A freeze is new unless both flags of the domain are already set.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frzPulse <= 1'b0;
    else       frzPulse <= frzValid && !(mmioFrz[frzDomain] && dmaFrz[frzDomain]);
  end

  assign stsMmio = mmioFrz[stsDomain];
  assign stsDma  = dmaFrz[stsDomain];

  // MSIs and inbound traffic follow the DMA flag; outbound MMIO follows the MMIO flag.
  logic useDma;
  logic blocked;
  assign useDma  = txInbound || (txKind == KIND_MSI);
  assign blocked = useDma ? dmaFrz[txDomain] : mmioFrz[txDomain];

  always_comb begin
    strobes.fwdEn = txValid && !blocked;
    strobes.cplEn = txValid && blocked && (txKind == KIND_LOAD);
  end

  p_freeze_both_r2: assert property (@(posedge clk) disable iff (!rstN)
    frzValid |=> (mmioFrz[$past(frzDomain)] && dmaFrz[$past(frzDomain)]));

  p_freeze_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    (frzValid && clrValid && frzDomain == clrDomain) |=>
      (mmioFrz[$past(clrDomain)] && dmaFrz[$past(clrDomain)]));

  p_clear_keeps_dma_r3: assert property (@(posedge clk) disable iff (!rstN)
    (clrValid && clrMmio && !clrDma && !frzValid) |=>
      (dmaFrz[$past(clrDomain)] == $past(dmaFrz[clrDomain])));

  p_clear_keeps_mmio_r3: assert property (@(posedge clk) disable iff (!rstN)
    (clrValid && clrDma && !clrMmio && !frzValid) |=>
      (mmioFrz[$past(clrDomain)] == $past(mmioFrz[clrDomain])));

  p_pulse_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    frzPulse |-> $past(frzValid));

endmodule

// File: rtl/frz_dp.sv
module frz_dp
  import frz_filter_pkg::*;
#(
  parameter int DOM_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobes_t      strobes,
  input  logic [1:0]        txKind,
  input  logic              txInbound,
  input  logic [DOM_W-1:0]  txDomain,
  input  logic [DATA_W-1:0] txData,
  output logic              fwdValid,
  output logic [1:0]        fwdKind,
  output logic              fwdInbound,
  output logic [DOM_W-1:0]  fwdDomain,
  output logic [DATA_W-1:0] fwdData,
  output logic              cplValid,
  output logic [DOM_W-1:0]  cplDomain,
  output logic [DATA_W-1:0] cplData
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fwdValid   <= 1'b0;
      fwdKind    <= '0;
      fwdInbound <= 1'b0;
      fwdDomain  <= '0;
      fwdData    <= '0;
    end else begin
      fwdValid <= strobes.fwdEn;
      if (strobes.fwdEn) begin
        fwdKind    <= txKind;
        fwdInbound <= txInbound;
        fwdDomain  <= txDomain;
        fwdData    <= txData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cplValid  <= 1'b0;
      cplDomain <= '0;
      cplData   <= '0;
    end else begin
      cplValid <= strobes.cplEn;
      if (strobes.cplEn) begin
        cplDomain <= txDomain;
        cplData   <= '1;
      end
    end
  end

  p_one_result_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(fwdValid && cplValid));

endmodule

// File: rtl/frz_filter.sv
module frz_filter
  import frz_filter_pkg::*;
#(
  parameter int NUM_DOM = 256,
  parameter int DATA_W  = 32,
  localparam int DOM_W  = $clog2(NUM_DOM)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frzValid,
  input  logic [DOM_W-1:0]  frzDomain,
  input  logic              clrValid,
  input  logic [DOM_W-1:0]  clrDomain,
  input  logic              clrMmio,
  input  logic              clrDma,
  input  logic              txValid,
  input  logic [1:0]        txKind,
  input  logic              txInbound,
  input  logic [DOM_W-1:0]  txDomain,
  input  logic [DATA_W-1:0] txData,
  input  logic [DOM_W-1:0]  stsDomain,
  output logic              stsMmio,
  output logic              stsDma,
  output logic              frzPulse,
  output logic              fwdValid,
  output logic [1:0]        fwdKind,
  output logic              fwdInbound,
  output logic [DOM_W-1:0]  fwdDomain,
  output logic [DATA_W-1:0] fwdData,
  output logic              cplValid,
  output logic [DOM_W-1:0]  cplDomain,
  output logic [DATA_W-1:0] cplData
);

  gateStrobes_t strobes;

  frz_ctrl #(.NUM_DOM(NUM_DOM)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .frzValid(frzValid), .frzDomain(frzDomain),
    .clrValid(clrValid), .clrDomain(clrDomain),
    .clrMmio(clrMmio), .clrDma(clrDma),
    .txValid(txValid), .txKind(txKind_e'(txKind)),
    .txInbound(txInbound), .txDomain(txDomain),
    .stsDomain(stsDomain), .stsMmio(stsMmio), .stsDma(stsDma),
    .frzPulse(frzPulse), .strobes(strobes)
  );

  frz_dp #(.DOM_W(DOM_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .txKind(txKind), .txInbound(txInbound),
    .txDomain(txDomain), .txData(txData),
    .fwdValid(fwdValid), .fwdKind(fwdKind), .fwdInbound(fwdInbound),
    .fwdDomain(fwdDomain), .fwdData(fwdData),
    .cplValid(cplValid), .cplDomain(cplDomain), .cplData(cplData)
  );

  p_fwd_copy_r8: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> ($past(txValid) && fwdData == $past(txData) &&
                  fwdDomain == $past(txDomain) && fwdKind == $past(txKind)));

  p_cpl_load_ones_r7: assert property (@(posedge clk) disable iff (!rstN)
    cplValid |-> ($past(txValid) && $past(txKind) == KIND_LOAD &&
                  (&cplData) && cplDomain == $past(txDomain)));

endmodule

// File: tb/frz_filter_bench.sv
`timescale 1ns/1ps
module frz_filter_bench;

  localparam int NUM_DOM = 256;
  localparam int DATA_W  = 32;
  localparam int DOM_W   = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frzValid = 0, clrValid = 0, clrMmio = 0, clrDma = 0;
  logic txValid = 0, txInbound = 0;
  logic [1:0] txKind = 0;
  logic [DOM_W-1:0] frzDomain = 0, clrDomain = 0, txDomain = 0, stsDomain = 0;
  logic [DATA_W-1:0] txData = 0;
  logic stsMmio, stsDma, frzPulse, fwdValid, fwdInbound, cplValid;
  logic [1:0] fwdKind;
  logic [DOM_W-1:0] fwdDomain, cplDomain;
  logic [DATA_W-1:0] fwdData, cplData;

  always #10 clk = ~clk;  // 50 MHz

  frz_filter #(.NUM_DOM(NUM_DOM), .DATA_W(DATA_W)) u_frz_filter (
    .clk(clk), .rstN(rstN),
    .frzValid(frzValid), .frzDomain(frzDomain),
    .clrValid(clrValid), .clrDomain(clrDomain), .clrMmio(clrMmio), .clrDma(clrDma),
    .txValid(txValid), .txKind(txKind), .txInbound(txInbound),
    .txDomain(txDomain), .txData(txData),
    .stsDomain(stsDomain), .stsMmio(stsMmio), .stsDma(stsDma), .frzPulse(frzPulse),
    .fwdValid(fwdValid), .fwdKind(fwdKind), .fwdInbound(fwdInbound),
    .fwdDomain(fwdDomain), .fwdData(fwdData),
    .cplValid(cplValid), .cplDomain(cplDomain), .cplData(cplData)
  );

  typedef struct {
    bit fwd; bit cpl; bit pulse;
    logic [1:0] kind; bit inb;
    logic [DOM_W-1:0] dom; logic [DATA_W-1:0] data;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  int vectors = 0;
  int errors  = 0;
  bit mMmio[NUM_DOM];
  bit mDma[NUM_DOM];
  bit monArmed = 0;

  // Drive one cycle of stimulus and push what the block must produce one cycle later.
  task automatic step(input bit fv, input int fd, input bit cv, input int cd,
                      input bit cm, input bit cdma, input bit tv, input logic [1:0] k,
                      input bit inb, input int td, input logic [DATA_W-1:0] dat,
                      input string req);
    expItem_t e;
    bit blk;
    @(negedge clk);
    frzValid = fv; frzDomain = DOM_W'(fd);
    clrValid = cv; clrDomain = DOM_W'(cd); clrMmio = cm; clrDma = cdma;
    txValid = tv; txKind = k; txInbound = inb; txDomain = DOM_W'(td); txData = dat;
    blk = (inb || k == 2'd2) ? mDma[td] : mMmio[td];
    e.fwd = tv && !blk;
    e.cpl = tv && blk && (k == 2'd0);
    e.pulse = fv && !(mMmio[fd] && mDma[fd]);
    e.kind = k; e.inb = inb; e.dom = DOM_W'(td); e.data = dat; e.req = req;
    expQ.push_back(e);
    if (cv) begin
      if (cm) mMmio[cd] = 0;
      if (cdma) mDma[cd] = 0;
    end
    if (fv) begin
      mMmio[fd] = 1; mDma[fd] = 1;
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 2'd0, 0, 0, '0, "R1");
  endtask

  task automatic tx(input logic [1:0] k, input bit inb, input int d,
                    input logic [DATA_W-1:0] dat, input string req);
    step(0, 0, 0, 0, 0, 0, 1, k, inb, d, dat, req);
  endtask

  task automatic checkSts(input int d, input bit em, input bit ed, input string req);
    @(negedge clk);
    frzValid = 0; clrValid = 0; txValid = 0;
    stsDomain = DOM_W'(d);
    #1;
    vectors++;
    if (stsMmio !== em || stsDma !== ed) begin
      errors++;
      $display("FAIL %s sts dom %0d: actual mmio=%b dma=%b expected mmio=%b dma=%b",
               req, d, stsMmio, stsDma, em, ed);
    end
  endtask

  // Monitor: after each edge, compare the outputs with the oldest expectation.
  always @(posedge clk) begin
    #2;
    if (monArmed && expQ.size() > 0) begin
      expItem_t e;
      bit bad;
      e = expQ.pop_front();
      vectors++;
      bad = (fwdValid !== e.fwd) || (cplValid !== e.cpl) || (frzPulse !== e.pulse);
      if (e.fwd && (fwdKind !== e.kind || fwdInbound !== e.inb ||
                    fwdDomain !== e.dom || fwdData !== e.data)) bad = 1;
      if (e.cpl && (cplData !== {DATA_W{1'b1}} || cplDomain !== e.dom)) bad = 1;
      if (bad) begin
        errors++;
        $display("FAIL %s: actual fwd=%b cpl=%b pulse=%b kind=%0d dom=%0d data=%h cpl=%h expected fwd=%b cpl=%b pulse=%b kind=%0d dom=%0d data=%h",
                 e.req, fwdValid, cplValid, frzPulse, fwdKind, fwdDomain, fwdData, cplData,
                 e.fwd, e.cpl, e.pulse, e.kind, e.dom, e.data);
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NUM_DOM; i++) begin mMmio[i] = 0; mDma[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    vectors++;
    if (fwdValid !== 0 || cplValid !== 0 || frzPulse !== 0) begin
      errors++;
      $display("FAIL R1: actual fwd=%b cpl=%b pulse=%b expected 0 0 0", fwdValid, cplValid, frzPulse);
    end
    checkSts(0, 0, 0, "R1");
    checkSts(255, 0, 0, "R1");
    rstN = 1;
    monArmed = 1;
    idle();
    // R8: pass-through while unfrozen
    tx(2'd0, 0, 5, 32'h1111_0001, "R8");
    tx(2'd1, 1, 5, 32'h2222_0002, "R8");
    tx(2'd2, 1, 5, 32'h3333_0003, "R8");
    // R10, R9, R2: freeze together with a load to the same domain
    step(1, 5, 0, 0, 0, 0, 1, 2'd0, 0, 5, 32'hA5A5_0004, "R10");
    checkSts(5, 1, 1, "R2");
    // R7, R6: frozen domain
    tx(2'd0, 0, 5, 32'h0000_0005, "R7");
    tx(2'd1, 0, 5, 32'h0000_0006, "R6");
    tx(2'd2, 1, 5, 32'h0000_0007, "R6");
    tx(2'd0, 1, 5, 32'h0000_0008, "R7");
    tx(2'd3, 0, 5, 32'h0000_0009, "R6");
    // R11: neighbours untouched
    tx(2'd1, 0, 4, 32'h4444_0004, "R11");
    tx(2'd1, 1, 6, 32'h6666_0006, "R11");
    checkSts(4, 0, 0, "R11");
    // R9: repeat freeze is silent
    step(1, 5, 0, 0, 0, 0, 0, 2'd0, 0, 0, '0, "R9");
    // R3: clear MMIO only
    step(0, 0, 1, 5, 1, 0, 0, 2'd0, 0, 0, '0, "R3");
    checkSts(5, 0, 1, "R3");
    // R5: outbound passes, inbound and MSI blocked by the DMA flag
    tx(2'd1, 0, 5, 32'h5555_000A, "R5");
    tx(2'd1, 1, 5, 32'h5555_000B, "R5");
    tx(2'd2, 0, 5, 32'h5555_000C, "R5");
    // R9: freeze a half-frozen domain pulses
    step(1, 5, 0, 0, 0, 0, 0, 2'd0, 0, 0, '0, "R9");
    // R3: clear DMA only
    step(0, 0, 1, 5, 0, 1, 0, 2'd0, 0, 0, '0, "R3");
    checkSts(5, 1, 0, "R3");
    // R5: MSI passes, outbound load blocked by the MMIO flag
    tx(2'd2, 1, 5, 32'h5555_000D, "R5");
    tx(2'd0, 0, 5, 32'h5555_000E, "R5");
    tx(2'd0, 1, 5, 32'h5555_000F, "R5");
    // R4: freeze and clear to the same domain
    step(1, 9, 1, 9, 1, 1, 0, 2'd0, 0, 0, '0, "R4");
    checkSts(9, 1, 1, "R4");
    checkSts(10, 0, 0, "R11");
    tx(2'd2, 1, 9, 32'h9999_0001, "R4");
    // Top domain: freeze, clear both, traffic resumes
    step(1, 255, 0, 0, 0, 0, 0, 2'd0, 0, 0, '0, "R9");
    tx(2'd1, 1, 255, 32'hFFFF_0001, "R6");
    step(0, 0, 1, 255, 1, 1, 0, 2'd0, 0, 0, '0, "R3");
    checkSts(255, 0, 0, "R3");
    tx(2'd0, 0, 255, 32'hFFFF_0002, "R8");
    // Clear on one domain while another freezes in the same cycle
    step(1, 20, 1, 9, 1, 1, 0, 2'd0, 0, 0, '0, "R9");
    checkSts(9, 0, 0, "R3");
    checkSts(20, 1, 1, "R2");
    idle();
    idle();
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule